// File: doc/BRIEF.md
# Pipelined Sine-Cosine Phase Converter

This block converts a stream of phase words into unit-circle points. Each phase word is an unsigned fraction of one full turn. For every accepted word the block returns sin(2π·phase) and cos(2π·phase) as two signed Q1.14 values packed into one output word. Sine sits in the upper half and cosine in the lower half, which gives {Q,I} order.

The computation is a rotation pipeline with one input stage, one stage per rotation step, and one output stage that rounds and saturates. The two most significant phase bits pick the quadrant. The remaining bits are rotated inside the first quadrant, and the result is mirrored back afterwards. Both sides use a valid/ready handshake. Every stage holds its contents when the stage after it cannot take data, so the block can stall at any point without losing or repeating a sample. A frame-end flag and a one-bit user flag travel with each sample. Reset is synchronous and active high, and it must be held for at least two clock cycles.

Top module: `sincos_conv`

## Requirements
- R1: For an accepted phase p, bits [31:16] of `out_sincos` carry round(16384·sin(2π·p/2^24)) and bits [15:0] carry round(16384·cos(2π·p/2^24)). Both are two's-complement Q1.14 values, each within ±2 LSB.
- R2: Phase bits [23:22] select the quadrant, and the residual bits [21:0] are rotated and then mirrored. Results at the quadrant boundaries, the octant points, 30°/60° and the words next to a full turn or a quarter turn meet the ±2 LSB tolerance of R1.
- R3: Both output fields stay inside [-16384, +16384]. Full scale shows as 16'h4000 and negative full scale as 16'hC000, with no wraparound.
- R4: `out_last` and `out_user` of each output equal `in_last` and `in_user` of the input sample that produced it.
- R5: Every accepted input produces exactly one output, and the outputs leave in the order the inputs arrived.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sincos`, `out_last` and `out_user` hold their values into the next cycle.
- R7: With `out_ready` held high and the pipeline empty, `out_valid` rises ITERS+1 clock edges after the edge that accepts the sample. With default parameters that is 17 edges.
- R8: `in_ready` is low only while every one of the ITERS+2 stages holds a sample and `out_ready` is low. With default parameters, 18 samples are accepted into a stalled block before `in_ready` drops.
- R9: `out_valid` is low after every clock edge at which `rst` is sampled high. Samples in flight at reset never appear. `in_ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_phase | input | 24 | Phase as an unsigned fraction of a turn |
| in_valid | input | 1 | Input sample valid |
| in_last | input | 1 | Frame-end flag of the input sample |
| in_user | input | 1 | User flag of the input sample |
| in_ready | output | 1 | Converter can take a sample |
| out_sincos | output | 32 | {sin, cos}, each signed Q1.14 |
| out_valid | output | 1 | Output sample valid |
| out_last | output | 1 | Frame-end flag of the output sample |
| out_user | output | 1 | User flag of the output sample |
| out_ready | input | 1 | Downstream can take a sample |

## Verification
The hardest state to reach from the ports is a completely full pipeline, where `in_ready` drops. Getting there takes exactly ITERS+2 accepted samples while the output is stalled. The stimulus holds `out_ready` low for a long window while feeding a continuous input stream. It then checks the accepted count and `in_ready` at the end of that window, and finally drains the pipeline and checks every sample. A second hard case is a reset arriving with samples in flight: the stimulus fills part of the pipeline, pulses reset for two cycles, and then watches that nothing comes out.

// File: rtl/sincos_pkg.sv
`timescale 1ns/1ps
package sincos_pkg;

    // Sideband flags that ride along with each sample
    typedef struct packed {
        logic last;
        logic user;
    } side_t;

    // Inverse rotation gain for a long run of steps
    localparam real CORDIC_KINV = 0.6072529350088813;

    // 2^32 / (2*pi), rounded
    localparam longint INV2PI_Q32 = 64'sd683565276;

    // atan(2^-idx) expressed in turns, scaled by 2^frac_bits.
    // Series in radians at scale 2^60, then converted to turns.
    function automatic longint step_angle(input int idx, input int frac_bits);
        longint acc;
        longint term;
        if (idx == 0) begin
            return longint'(1) <<< (frac_bits - 3);
        end
        acc = 0;
        for (int k = 1; k < 40; k += 2) begin
            if (idx * k < 60) begin
                term = (longint'(1) <<< (60 - idx * k)) / longint'(k);
                if (((k - 1) / 2) % 2 == 1) acc = acc - term;
                else                        acc = acc + term;
            end
        end
        acc = (acc >>> 28) * INV2PI_Q32;
        return (acc + (longint'(1) <<< (63 - frac_bits))) >>> (64 - frac_bits);
    endfunction

endpackage

// File: rtl/sincos_front.sv
`timescale 1ns/1ps
module sincos_front
    import sincos_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int XF      = 20,
    parameter int XW      = 23,
    parameter int AW      = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PHASE_W-1:0]   in_phase,
    input  logic                 in_valid,
    input  side_t                in_side,
    output logic                 in_ready,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [XW-1:0] out_x,
    output logic signed [XW-1:0] out_y,
    output logic signed [AW-1:0] out_z,
    output logic [1:0]           out_quad,
    output side_t                out_side
);
    localparam int SHIFT = AW - PHASE_W;
    localparam int X0    = $rtoi(CORDIC_KINV * (2.0 ** XF) + 0.5);
    localparam logic signed [XW-1:0] X0V = XW'(X0);

    logic signed [AW-1:0] z_start;

    // residual angle inside the first quadrant, rescaled to the angle grid
    assign z_start  = {{(SHIFT + 2){1'b0}}, in_phase[PHASE_W-3:0]} <<< SHIFT;
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            out_x    <= X0V;
            out_y    <= '0;
            out_z    <= z_start;
            out_quad <= in_phase[PHASE_W-1:PHASE_W-2];
            out_side <= in_side;
        end
    end

endmodule

// File: rtl/sincos_rot.sv
`timescale 1ns/1ps
module sincos_rot
    import sincos_pkg::*;
#(
    parameter int XW  = 23,
    parameter int AW  = 26,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [XW-1:0] in_x,
    input  logic signed [XW-1:0] in_y,
    input  logic signed [AW-1:0] in_z,
    input  logic [1:0]           in_quad,
    input  side_t                in_side,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [XW-1:0] out_x,
    output logic signed [XW-1:0] out_y,
    output logic signed [AW-1:0] out_z,
    output logic [1:0]           out_quad,
    output side_t                out_side
);
    localparam longint STEP_L = step_angle(IDX, AW);
    localparam logic signed [AW-1:0] STEP = STEP_L[AW-1:0];

    logic signed [XW-1:0] x_sh, y_sh, x_nx, y_nx;
    logic signed [AW-1:0] z_nx;

    assign x_sh     = in_x >>> IDX;
    assign y_sh     = in_y >>> IDX;
    assign in_ready = !out_valid || out_ready;

    // rotate toward zero residual angle
    always_comb begin
        if (!in_z[AW-1]) begin
            x_nx = in_x - y_sh;
            y_nx = in_y + x_sh;
            z_nx = in_z - STEP;
        end else begin
            x_nx = in_x + y_sh;
            y_nx = in_y - x_sh;
            z_nx = in_z + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            out_x    <= x_nx;
            out_y    <= y_nx;
            out_z    <= z_nx;
            out_quad <= in_quad;
            out_side <= in_side;
        end
    end

    // R6: an occupied stage keeps its sample while the next stage is full
    a_r6_stage_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_side));

endmodule

// File: rtl/sincos_back.sv
`timescale 1ns/1ps
module sincos_back
    import sincos_pkg::*;
#(
    parameter int XW     = 23,
    parameter int AW     = 26,
    parameter int HW     = 16,
    parameter int FRAC_W = 14,
    parameter int GUARD  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [XW-1:0] in_x,
    input  logic signed [XW-1:0] in_y,
    input  logic signed [AW-1:0] in_z,
    input  logic [1:0]           in_quad,
    input  side_t                in_side,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2*HW-1:0]      out_sincos,
    output logic                 out_last,
    output logic                 out_user
);
    localparam logic signed [XW-1:0] RND = XW'(1) <<< (GUARD - 1);
    localparam logic signed [XW-1:0] LIM = XW'(1) <<< FRAC_W;
    localparam logic signed [AW-1:0] ZTOL = AW'(1024);

    logic signed [XW-1:0] c_raw, s_raw;

    function automatic logic [HW-1:0] to_fixed(input logic signed [XW-1:0] v);
        logic signed [XW-1:0] t;
        t = (v + RND) >>> GUARD;
        if (t > LIM)       t = LIM;
        else if (t < -LIM) t = -LIM;
        return t[HW-1:0];
    endfunction

    // mirror the first-quadrant result into the selected quadrant
    always_comb begin
        unique case (in_quad)
            2'd0: begin c_raw =  in_x; s_raw =  in_y; end
            2'd1: begin c_raw = -in_y; s_raw =  in_x; end
            2'd2: begin c_raw = -in_x; s_raw = -in_y; end
            2'd3: begin c_raw =  in_y; s_raw = -in_x; end
        endcase
    end

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            out_sincos <= {to_fixed(s_raw), to_fixed(c_raw)};
            out_last   <= in_side.last;
            out_user   <= in_side.user;
        end
    end

    // R1: the rotation has driven the residual angle close to zero
    a_r1_residual: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (in_z < ZTOL) && (in_z > -ZTOL));

    // R3: both fields stay within full scale
    a_r3_clamp: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_sincos[2*HW-1:HW]) <= $signed(LIM[HW-1:0]))
                   && ($signed(out_sincos[2*HW-1:HW]) >= -$signed(LIM[HW-1:0]))
                   && ($signed(out_sincos[HW-1:0])    <= $signed(LIM[HW-1:0]))
                   && ($signed(out_sincos[HW-1:0])    >= -$signed(LIM[HW-1:0])));

    // R6: a stalled output word holds
    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_sincos)
                                 && $stable(out_last) && $stable(out_user));

    // R9: reset empties the output
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/sincos_conv.sv
`timescale 1ns/1ps
module sincos_conv
    import sincos_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int HW      = 16,
    parameter int FRAC_W  = 14,
    parameter int ITERS   = 16,
    parameter int GUARD   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] in_phase,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic               in_user,
    output logic               in_ready,
    output logic [2*HW-1:0]    out_sincos,
    output logic               out_valid,
    output logic               out_last,
    output logic               out_user,
    input  logic               out_ready
);
    localparam int XF = FRAC_W + GUARD;
    localparam int XW = XF + 3;
    localparam int AW = PHASE_W + 2;

    logic                 v_s    [0:ITERS];
    logic                 r_s    [0:ITERS];
    logic signed [XW-1:0] x_s    [0:ITERS];
    logic signed [XW-1:0] y_s    [0:ITERS];
    logic signed [AW-1:0] z_s    [0:ITERS];
    logic [1:0]           q_s    [0:ITERS];
    side_t                side_s [0:ITERS];
    side_t                side_in;

    assign side_in = '{last: in_last, user: in_user};

    sincos_front #(.PHASE_W(PHASE_W), .XF(XF), .XW(XW), .AW(AW)) u_front (
        .clk(clk), .rst(rst),
        .in_phase(in_phase), .in_valid(in_valid), .in_side(side_in), .in_ready(in_ready),
        .out_valid(v_s[0]), .out_ready(r_s[0]),
        .out_x(x_s[0]), .out_y(y_s[0]), .out_z(z_s[0]), .out_quad(q_s[0]), .out_side(side_s[0])
    );

    for (genvar g = 0; g < ITERS; g++) begin : g_rot
        sincos_rot #(.XW(XW), .AW(AW), .IDX(g)) u_rot (
            .clk(clk), .rst(rst),
            .in_valid(v_s[g]), .in_ready(r_s[g]),
            .in_x(x_s[g]), .in_y(y_s[g]), .in_z(z_s[g]), .in_quad(q_s[g]), .in_side(side_s[g]),
            .out_valid(v_s[g+1]), .out_ready(r_s[g+1]),
            .out_x(x_s[g+1]), .out_y(y_s[g+1]), .out_z(z_s[g+1]),
            .out_quad(q_s[g+1]), .out_side(side_s[g+1])
        );
    end

    sincos_back #(.XW(XW), .AW(AW), .HW(HW), .FRAC_W(FRAC_W), .GUARD(GUARD)) u_back (
        .clk(clk), .rst(rst),
        .in_valid(v_s[ITERS]), .in_ready(r_s[ITERS]),
        .in_x(x_s[ITERS]), .in_y(y_s[ITERS]), .in_z(z_s[ITERS]),
        .in_quad(q_s[ITERS]), .in_side(side_s[ITERS]),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sincos(out_sincos), .out_last(out_last), .out_user(out_user)
    );

    // R8: input refuses only when the whole chain is full and stalled
    a_r8_ready_low: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid && !out_ready && v_s[0]);

endmodule

// File: tb/sincos_conv_bench.sv
`timescale 1ns/1ps
module sincos_conv_bench;
    localparam int ITERS = 16;
    localparam int NV    = 12;
    localparam int QN    = 512;

    // phase, expected sin, expected cos
    localparam logic [55:0] VEC [NV] = '{
        {24'h000000, 16'h0000, 16'h4000},
        {24'h200000, 16'h2D41, 16'h2D41},
        {24'h400000, 16'h4000, 16'h0000},
        {24'h600000, 16'h2D41, 16'hD2BF},
        {24'h800000, 16'h0000, 16'hC000},
        {24'hA00000, 16'hD2BF, 16'hD2BF},
        {24'hC00000, 16'hC000, 16'h0000},
        {24'hE00000, 16'hD2BF, 16'h2D41},
        {24'h155555, 16'h2000, 16'h376D},
        {24'h2AAAAB, 16'h376D, 16'h2000},
        {24'hFFFFFF, 16'h0000, 16'h4000},
        {24'h3FFFFF, 16'h4000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] in_phase = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_user = 1'b0;
    logic        in_ready;
    logic [31:0] out_sincos;
    logic        out_valid;
    logic        out_last;
    logic        out_user;
    logic        out_ready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    logic [23:0] ph_q   [QN];
    int          es_q   [QN];
    int          ec_q   [QN];
    bit          last_q [QN];
    bit          user_q [QN];
    bit          vec_q  [QN];
    int wr = 0, rd = 0, di = 0;

    always #10 clk = ~clk;

    sincos_conv u_sincos_conv (
        .clk(clk), .rst(rst),
        .in_phase(in_phase), .in_valid(in_valid), .in_last(in_last), .in_user(in_user),
        .in_ready(in_ready),
        .out_sincos(out_sincos), .out_valid(out_valid), .out_last(out_last), .out_user(out_user),
        .out_ready(out_ready)
    );

    task automatic check(input string req, input int got, input int exp, input int tol);
        n_checks++;
        if (got - exp > tol || exp - got > tol) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int ref_val(input logic [23:0] p, input bit want_sin);
        real a, r;
        a = 6.283185307179586 * real'(p) / 16777216.0;
        r = 16384.0 * (want_sin ? $sin(a) : $cos(a));
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic clear_q();
        wr = 0; rd = 0; di = 0;
    endtask

    task automatic push(input logic [23:0] p, input int s, input int c, input bit is_vec);
        ph_q[wr]   = p;
        es_q[wr]   = s;
        ec_q[wr]   = c;
        last_q[wr] = (wr % 5 == 4);
        user_q[wr] = 1'($urandom_range(1));
        vec_q[wr]  = is_vec;
        wr++;
    endtask

    task automatic push_random(input int n);
        for (int i = 0; i < n; i++) begin
            logic [23:0] p;
            p = 24'($urandom);
            push(p, ref_val(p, 1'b1), ref_val(p, 1'b0), 1'b0);
        end
    endtask

    // mode 0: always ready; mode 1: random valid and ready; mode 2: output stalled for hold cycles
    task automatic run(input int mode, input int hold);
        int          cyc = 0;
        bit          pend = 0;
        bit          stall_prev = 0;
        logic [33:0] prev = '0;
        while ((rd < wr || cyc < hold + 2) && cyc < 6000) begin
            @(negedge clk);
            if (!pend) begin
                if (di < wr && (mode != 1 || $urandom_range(3) != 0)) begin
                    in_valid = 1'b1;
                    in_phase = ph_q[di];
                    in_last  = last_q[di];
                    in_user  = user_q[di];
                end else begin
                    in_valid = 1'b0;
                    in_phase = 24'($urandom);
                    in_last  = 1'b0;
                    in_user  = 1'b0;
                end
            end
            case (mode)
                0:       out_ready = 1'b1;
                1:       out_ready = ($urandom_range(2) != 0);
                default: out_ready = (cyc >= hold);
            endcase
            #5;
            if (mode == 2 && cyc == hold - 1) begin
                check("R8 samples taken while stalled", di, ITERS + 2, 0);
                check("R8 in_ready when full", int'(in_ready), 0, 0);
            end
            if (stall_prev) begin
                check("R6 valid held", int'(out_valid), 1, 0);
                check("R6 word held", int'({out_sincos, out_last, out_user} == prev), 1, 0);
            end
            pend = in_valid && !in_ready;
            if (in_valid && in_ready) di++;
            if (out_valid && out_ready) begin
                if (rd >= wr) begin
                    check("R5 unexpected output", rd, wr - 1, 0);
                end else begin
                    int s, c;
                    s = int'($signed(out_sincos[31:16]));
                    c = int'($signed(out_sincos[15:0]));
                    check(vec_q[rd] ? "R2 sin" : "R1 sin", s, es_q[rd], 2);
                    check(vec_q[rd] ? "R2 cos" : "R1 cos", c, ec_q[rd], 2);
                    check("R3 in range", int'(s <= 16384 && s >= -16384 && c <= 16384 && c >= -16384), 1, 0);
                    check("R4 last", int'(out_last), int'(last_q[rd]), 0);
                    check("R4 user", int'(out_user), int'(user_q[rd]), 0);
                end
                rd++;
            end
            stall_prev = out_valid && !out_ready;
            prev = {out_sincos, out_last, out_user};
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 all samples delivered", rd, wr, 0);
    endtask

    task automatic idle_quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #5;
            if (out_valid) seen++;
        end
        check(req, seen, 0, 0);
    endtask

    initial begin
        #(100000 * 20);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R9 out_valid during reset", int'(out_valid), 0, 0);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check("R9 in_ready after reset", int'(in_ready), 1, 0);

        // vector table
        clear_q();
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][55:32], int'($signed(VEC[i][31:16])), int'($signed(VEC[i][15:0])), 1'b1);
        end
        run(0, 0);

        // random phases, free flowing
        clear_q(); push_random(60); run(0, 0);
        // random phases, random bubbles and backpressure
        clear_q(); push_random(200); run(1, 0);
        // full pipeline under a long stall
        clear_q(); push_random(30); run(2, 40);
        idle_quiet("R5 no duplicate after drain", 30);

        // R7 latency from accept to output
        begin
            int lat = 0;
            @(negedge clk);
            out_ready = 1'b1;
            in_phase  = 24'h100000;
            in_valid  = 1'b1;
            #5;
            check("R7 ready before latency probe", int'(in_ready), 1, 0);
            @(posedge clk);
            #2;
            in_valid = 1'b0;
            for (int k = 1; k <= 40; k++) begin
                @(posedge clk);
                #2;
                if (out_valid && lat == 0) lat = k;
            end
            check("R7 latency edges", lat, ITERS + 1, 0);
        end

        // R9 reset with samples in flight
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_phase = 24'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #5;
        check("R9 in_ready after mid-stream reset", int'(in_ready), 1, 0);
        idle_quiet("R9 flushed samples never appear", 30);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule